// File: doc/BRIEF.md
# Double-Buffered One-Shot DMA Channel Bank

This block holds seven single-pass DMA channels behind one 32-bit register port. Every channel owns two descriptor slots, and each slot holds a start address, a byte length and a command word. Only one slot per channel is live. While the live slot moves data, software fills in the other slot. When the live slot finishes, the channel moves to the other slot.

A peripheral asks for service by raising its request line. When a channel can run, the bank forwards the request to a single-word memory port. The request goes out in the same cycle, taken from the channel's current address. In the cycle memory grants it, the bank pulses that channel's acknowledge. Read data passes from memory to the peripheral data output. Write data passes from the peripheral data input to memory. A done flag for each slot is both visible on a port and readable through the command word.

The channels, in order from highest to lowest service priority, are:

| Index | Channel |
|---|---|
| 0 | disk |
| 1 | network receive |
| 2 | network transmit |
| 3 | floppy |
| 4 | serial A receive |
| 5 | serial B receive |
| 6 | serial A transmit |

Top module: `dma_pingpong_bank`

## Requirements
- R1: After reset, every register reads zero, `mem_req` is low, `dack` is zero, `set_done` is zero, and every channel's live slot is slot 0.
- R2: The control register of channel c sits at 0xC00 + 0x10·c. Bit 0 is the channel enable (read/write). Bit 8 is read-only and shows the live slot. The descriptor slot s of channel c starts at 0x1000 + 0x20·c + 0x10·s, with the address at +0x0, the length at +0x4 (16 bits) and the command at +0x8. Each value reads back as written.
- R3: Command bit 0 arms a slot. Command bit 1 selects direction: 1 means peripheral data is written to memory, 0 means memory is read out to the peripheral. Command bit 4 is the done flag and reads back. Writing 1 to bit 4 clears the flag; writing 0 there leaves it unchanged.
- R4: A channel issues memory requests only while its request line is high, its enable bit is set, and its live slot is armed with a nonzero word count. A disabled channel or an unarmed slot produces no `mem_req`.
- R5: Each word is one memory request at the slot's current address. `dack` pulses only in a cycle where `mem_gnt` is high. While `mem_gnt` is low, the address and length hold. Each granted word adds 4 to the address and subtracts 4 from the length.
- R6: When the last word of a slot is granted, that slot's arm bit clears, its done flag sets, its length reads 0, and the live slot toggles.
- R7: If the newly live slot is already armed, it is served from the very next cycle. Otherwise the channel stays idle, whatever its request line does.
- R8: The length register counts bytes, and its low two bits are ignored. A slot armed with fewer than 4 bytes on an enabled channel completes one cycle later without touching memory.
- R9: When several channels can be served, the lowest-numbered one is granted. At most one `dack` bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 13 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dreq | input | 7 | Per-channel service request |
| dack | output | 7 | Per-channel word acknowledge |
| pdata_in | input | 32 | Peripheral data headed for memory |
| pdata_out | output | 32 | Memory data headed for the peripheral |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the grant cycle |
| mem_gnt | input | 1 | Memory accepts the word this cycle |
| set_done | output | 14 | Done flag, bit 2·c + s for slot s of channel c |

## Verification
The assertions assume that `mem_gnt` only matters while `mem_req` is high, and that read data is valid in the same cycle as the grant. They also assume software never rewrites the live slot's address or length in the cycle a word completes. The bench therefore programs a slot before enabling or arming it, and raises `dreq` only after setup has finished. It drives `mem_gnt` low only when it is deliberately testing a stall.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
  localparam int REG_AW   = 13;
  localparam int DATA_W   = 32;
  localparam int CH_IDX_W = 4;

  localparam logic [REG_AW-1:0] CTL_BASE  = 13'h0C00;
  localparam logic [REG_AW-1:0] DESC_BASE = 13'h1000;
  localparam int CTL_STRIDE  = 16;
  localparam int DESC_STRIDE = 32;

  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_ACT_BIT   = 8;
  localparam int CMD_ARM_BIT   = 0;
  localparam int CMD_TOMEM_BIT = 1;
  localparam int CMD_DONE_BIT  = 4;

  typedef enum logic [1:0] {FLD_ADDR = 2'd0, FLD_LEN = 2'd1, FLD_CMD = 2'd2, FLD_NONE = 2'd3} fld_e;

  typedef struct packed {
    logic                ctl_hit;
    logic                desc_hit;
    logic [CH_IDX_W-1:0] ch;
    logic                slot;
    fld_e                fld;
  } reg_dec_t;

  function automatic logic [DATA_W-1:0] addr_step(input logic [DATA_W-1:0] a);
    return a + 32'd4;
  endfunction

  function automatic logic [DATA_W-1:0] words_of(input logic [DATA_W-1:0] len_bytes);
    return len_bytes >> 2;
  endfunction

  function automatic logic [DATA_W-1:0] len_step(input logic [DATA_W-1:0] len_bytes);
    return len_bytes - 32'd4;
  endfunction
endpackage

// File: rtl/dma_pp_regdec.sv
module dma_pp_regdec
  import dma_pp_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic [REG_AW-1:0] addr,
  output reg_dec_t          dec
);
  localparam logic [REG_AW-1:0] CTL_SPAN  = REG_AW'(NUM_CH * CTL_STRIDE);
  localparam logic [REG_AW-1:0] DESC_SPAN = REG_AW'(NUM_CH * DESC_STRIDE);

  logic [REG_AW-1:0] off_ctl, off_desc;

  assign off_ctl  = addr - CTL_BASE;
  assign off_desc = addr - DESC_BASE;

  always_comb begin
    dec = '0;
    dec.fld = FLD_NONE;
    if (addr >= CTL_BASE && off_ctl < CTL_SPAN && off_ctl[3:0] == 4'h0) begin
      dec.ctl_hit = 1'b1;
      dec.ch      = off_ctl[7:4];
    end else if (addr >= DESC_BASE && off_desc < DESC_SPAN && off_desc[1:0] == 2'b00
                 && off_desc[3:2] != 2'b11) begin
      dec.desc_hit = 1'b1;
      dec.ch       = off_desc[8:5];
      dec.slot     = off_desc[4];
      dec.fld      = fld_e'(off_desc[3:2]);
    end
  end
endmodule

// File: rtl/dma_pp_prio.sv
module dma_pp_prio #(
  parameter int N = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IW'(i);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/dma_pp_channel.sv
module dma_pp_channel
  import dma_pp_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_we,
  input  logic [1:0]             addr_we,
  input  logic [1:0]             len_we,
  input  logic [1:0]             cmd_we,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   xfer_i,
  output logic                   eligible_o,
  output logic                   complete_o,
  output logic [DATA_W-1:0]      cur_addr_o,
  output logic                   cur_tomem_o,
  output logic                   enable_o,
  output logic                   active_o,
  output logic [1:0][DATA_W-1:0] addr_rd_o,
  output logic [1:0][DATA_W-1:0] len_rd_o,
  output logic [1:0][DATA_W-1:0] cmd_rd_o,
  output logic [1:0]             done_o
);
  logic                   en_q, act_q;
  logic [1:0][DATA_W-1:0] addr_q;
  logic [1:0][LEN_W-1:0]  len_q;
  logic [1:0]             arm_q, tomem_q, done_q;

  logic [DATA_W-1:0] words_live;
  logic              live_run, last_word, empty_fire;

  assign words_live = words_of(DATA_W'(len_q[act_q]));
  assign live_run   = en_q & arm_q[act_q];
  assign eligible_o = live_run && (words_live != '0);
  assign last_word  = xfer_i && (words_live == 32'd1);
  assign empty_fire = live_run && (words_live == '0);
  assign complete_o = last_word | empty_fire;

  assign cur_addr_o  = addr_q[act_q];
  assign cur_tomem_o = tomem_q[act_q];
  assign enable_o    = en_q;
  assign active_o    = act_q;
  assign done_o      = done_q;

  for (genvar s = 0; s < 2; s++) begin : g_rd
    assign addr_rd_o[s] = addr_q[s];
    assign len_rd_o[s]  = DATA_W'(len_q[s]);
    always_comb begin
      cmd_rd_o[s] = '0;
      cmd_rd_o[s][CMD_ARM_BIT]   = arm_q[s];
      cmd_rd_o[s][CMD_TOMEM_BIT] = tomem_q[s];
      cmd_rd_o[s][CMD_DONE_BIT]  = done_q[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      act_q   <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      arm_q   <= '0;
      tomem_q <= '0;
      done_q  <= '0;
    end else begin
      if (ctl_we) en_q <= wdata[CTL_EN_BIT];
      for (int s = 0; s < 2; s++) begin
        if (addr_we[s]) addr_q[s] <= wdata;
        if (len_we[s])  len_q[s]  <= wdata[LEN_W-1:0];
        if (cmd_we[s]) begin
          arm_q[s]   <= wdata[CMD_ARM_BIT];
          tomem_q[s] <= wdata[CMD_TOMEM_BIT];
          if (wdata[CMD_DONE_BIT]) done_q[s] <= 1'b0;
        end
      end
      // hardware progress takes precedence over a same-cycle software write
      if (xfer_i) begin
        addr_q[act_q] <= addr_step(addr_q[act_q]);
        len_q[act_q]  <= LEN_W'(len_step(DATA_W'(len_q[act_q])));
      end
      if (complete_o) begin
        arm_q[act_q]  <= 1'b0;
        done_q[act_q] <= 1'b1;
        len_q[act_q]  <= '0;
        act_q         <= ~act_q;
      end
    end
  end

  assert_xfer_needs_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_i |-> eligible_o);

  assert_addr_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_i |=> addr_q[$past(act_q)] == $past(addr_q[act_q]) + 32'd4);

  assert_complete_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |=> act_q != $past(act_q));

  assert_complete_marks_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |=> done_q[$past(act_q)] && !arm_q[$past(act_q)]);

  assert_idle_holds_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !complete_o |=> $stable(act_q));
endmodule

// File: rtl/dma_pingpong_bank.sv
module dma_pingpong_bank
  import dma_pp_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int LEN_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_CH-1:0]     dreq,
  output logic [NUM_CH-1:0]     dack,
  input  logic [DATA_W-1:0]     pdata_in,
  output logic [DATA_W-1:0]     pdata_out,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [DATA_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  input  logic                  mem_gnt,
  output logic [2*NUM_CH-1:0]   set_done
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  reg_dec_t dec;

  logic [NUM_CH-1:0] elig_v, en_v, act_v, tomem_v, cand, grant;
  logic [CH_W-1:0]   gidx, ridx;
  logic              any_cand;

  logic [DATA_W-1:0]      cur_addr_v [NUM_CH];
  logic [1:0][DATA_W-1:0] addr_rd_v  [NUM_CH];
  logic [1:0][DATA_W-1:0] len_rd_v   [NUM_CH];
  logic [1:0][DATA_W-1:0] cmd_rd_v   [NUM_CH];
  logic [NUM_CH-1:0]      complete_v;

  dma_pp_regdec #(.NUM_CH(NUM_CH)) u_dec (.addr(reg_addr), .dec(dec));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic       ch_sel;
    logic [1:0] slot_sel;
    assign ch_sel   = reg_we && (dec.ch == CH_IDX_W'(c));
    assign slot_sel = dec.slot ? 2'b10 : 2'b01;

    dma_pp_channel #(.LEN_W(LEN_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we     (ch_sel && dec.ctl_hit),
      .addr_we    ((ch_sel && dec.desc_hit && dec.fld == FLD_ADDR) ? slot_sel : 2'b00),
      .len_we     ((ch_sel && dec.desc_hit && dec.fld == FLD_LEN)  ? slot_sel : 2'b00),
      .cmd_we     ((ch_sel && dec.desc_hit && dec.fld == FLD_CMD)  ? slot_sel : 2'b00),
      .wdata      (reg_wdata),
      .xfer_i     (dack[c]),
      .eligible_o (elig_v[c]),
      .complete_o (complete_v[c]),
      .cur_addr_o (cur_addr_v[c]),
      .cur_tomem_o(tomem_v[c]),
      .enable_o   (en_v[c]),
      .active_o   (act_v[c]),
      .addr_rd_o  (addr_rd_v[c]),
      .len_rd_o   (len_rd_v[c]),
      .cmd_rd_o   (cmd_rd_v[c]),
      .done_o     (set_done[2*c +: 2])
    );
  end

  // service path: fixed priority, one word per grant
  assign cand = dreq & elig_v;

  dma_pp_prio #(.N(NUM_CH)) u_prio (.req(cand), .grant(grant), .idx(gidx), .any(any_cand));

  assign mem_req   = any_cand;
  assign mem_we    = tomem_v[gidx];
  assign mem_addr  = cur_addr_v[gidx];
  assign mem_wdata = pdata_in;
  assign pdata_out = mem_rdata;
  assign dack      = mem_gnt ? grant : '0;

  // register read path
  assign ridx = dec.ch[CH_W-1:0];

  always_comb begin
    reg_rdata = '0;
    if (dec.ctl_hit) begin
      reg_rdata[CTL_EN_BIT]  = en_v[ridx];
      reg_rdata[CTL_ACT_BIT] = act_v[ridx];
    end else if (dec.desc_hit) begin
      case (dec.fld)
        FLD_ADDR: reg_rdata = addr_rd_v[ridx][dec.slot];
        FLD_LEN:  reg_rdata = len_rd_v[ridx][dec.slot];
        FLD_CMD:  reg_rdata = cmd_rd_v[ridx][dec.slot];
        default:  reg_rdata = '0;
      endcase
    end
  end

  assert_one_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (grant != '0) && ((grant & cand) == grant)
                && ((cand & (grant - 1'b1)) == '0));

  assert_ack_only_on_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |-> mem_gnt && mem_req);

  assert_done_only_on_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_v == '0) |=> (set_done & ~$past(set_done)) == '0);
endmodule

// File: tb/dma_pingpong_bank_test.sv
module dma_pingpong_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  dreq = '0;
  logic [6:0]  dack;
  logic [31:0] pdata_in = '0;
  logic [31:0] pdata_out;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_gnt = 1'b1;
  logic [13:0] set_done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [31:0] last_waddr = '0, last_wdata = '0;
  int          nwrites = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem_addr ^ 32'hA5A5_0000;

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_gnt && mem_we) begin
      last_waddr <= mem_addr;
      last_wdata <= mem_wdata;
      nwrites    <= nwrites + 1;
    end
  end

  dma_pingpong_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
    .pdata_in(pdata_in), .pdata_out(pdata_out), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .set_done(set_done)
  );

  function automatic logic [12:0] ctl_a(input int ch);
    return 13'(12'hC00 + 16 * ch);
  endfunction
  function automatic logic [12:0] desc_a(input int ch, input int slot, input int fld);
    return 13'(16'h1000 + 32 * ch + 16 * slot + 4 * fld);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [12:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic load_slot(input int ch, input int slot, input logic [31:0] a,
                           input logic [31:0] len, input logic [31:0] cmd);
    reg_write(desc_a(ch, slot, 0), a);
    reg_write(desc_a(ch, slot, 1), len);
    reg_write(desc_a(ch, slot, 2), cmd);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1", "mem_req", 32'(mem_req), 0);
    check("R1", "dack", 32'(dack), 0);
    check("R1", "set_done", 32'(set_done), 0);
    reg_read(ctl_a(3), v);        check("R1", "ctl3", v, 0);
    reg_read(desc_a(4, 1, 2), v); check("R1", "cmd4.1", v, 0);
    reg_read(desc_a(6, 0, 0), v); check("R1", "addr6.0", v, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    reg_write(desc_a(4, 1, 0), 32'hCAFE_0010);
    reg_write(desc_a(4, 1, 1), 32'h0001_1234);
    reg_write(desc_a(4, 0, 2), 32'h0000_0002);
    reg_read(desc_a(4, 1, 0), v); check("R2", "addr4.1", v, 32'hCAFE_0010);
    reg_read(desc_a(4, 1, 1), v); check("R2", "len4.1 16-bit", v, 32'h0000_1234);
    reg_read(desc_a(4, 0, 0), v); check("R2", "addr4.0 untouched", v, 0);
    reg_read(desc_a(4, 0, 2), v); check("R3", "cmd dir bit", v, 32'h2);
    reg_write(ctl_a(4), 32'h1);
    reg_read(ctl_a(4), v); check("R2", "ctl4 enable", v, 32'h1);
    reg_write(ctl_a(4), 32'h0);
    reg_write(desc_a(4, 0, 2), 32'h0);
  endtask

  task automatic t_disabled_and_stall;
    logic [31:0] v;
    load_slot(0, 0, 32'h0000_0040, 32'd6, 32'h1);
    @(negedge clk); dreq[0] = 1'b1; #1;
    check("R4", "disabled no req", 32'(mem_req), 0);
    reg_write(ctl_a(0), 32'h1);
    #1;
    check("R4", "enabled req", 32'(mem_req), 1);
    mem_gnt = 1'b0; #1;
    check("R5", "no dack without gnt", 32'(dack), 0);
    @(negedge clk); #1;
    reg_read(desc_a(0, 0, 0), v); check("R5", "addr held in stall", v, 32'h40);
    mem_gnt = 1'b1; #1;
    check("R5", "dack ch0", 32'(dack), 32'h1);
    check("R5", "read data path", pdata_out, 32'hA5A5_0040);
    @(negedge clk); dreq[0] = 1'b0; #1;
    check("R8", "len 6 is one word", 32'(set_done[0]), 1);
    reg_read(ctl_a(0), v); check("R6", "ch0 live slot 1", v, 32'h101);
    reg_read(desc_a(0, 0, 0), v); check("R5", "addr advanced", v, 32'h44);
  endtask

  task automatic t_single_then_idle;
    logic [31:0] v;
    load_slot(1, 0, 32'h0000_0100, 32'd8, 32'h1);
    reg_write(ctl_a(1), 32'h1);
    dreq[1] = 1'b1; #1;
    check("R5", "word0 addr", mem_addr, 32'h100);
    check("R5", "word0 dack", 32'(dack), 32'h2);
    check("R3", "read dir", 32'(mem_we), 0);
    @(negedge clk); #1;
    check("R5", "word1 addr", mem_addr, 32'h104);
    reg_read(desc_a(1, 0, 1), v); check("R5", "len after one word", v, 32'd4);
    @(negedge clk); #1;
    check("R7", "other slot unarmed idles", 32'(mem_req), 0);
    check("R6", "done slot0 ch1", 32'(set_done[2]), 1);
    reg_read(desc_a(1, 0, 2), v); check("R6", "cmd arm clear done set", v, 32'h10);
    reg_read(desc_a(1, 0, 1), v); check("R6", "len zero", v, 0);
    reg_read(ctl_a(1), v); check("R6", "live slot 1", v, 32'h101);
    @(negedge clk); #1;
    check("R7", "still idle", 32'(mem_req), 0);
    dreq[1] = 1'b0;
  endtask

  task automatic t_done_clear;
    logic [31:0] v;
    reg_write(desc_a(1, 0, 2), 32'h0);
    check("R3", "write 0 keeps done", 32'(set_done[2]), 1);
    reg_write(desc_a(1, 0, 2), 32'h10);
    check("R3", "write 1 clears done", 32'(set_done[2]), 0);
    reg_read(desc_a(1, 0, 2), v); check("R3", "cmd reads clear", v, 0);
  endtask

  task automatic t_pingpong;
    int w0;
    load_slot(3, 0, 32'h0000_0200, 32'd4, 32'h1);
    load_slot(3, 1, 32'h0000_0300, 32'd4, 32'h3);
    reg_write(ctl_a(3), 32'h1);
    pdata_in = 32'hDEAD_BEEF;
    w0 = nwrites;
    dreq[3] = 1'b1; #1;
    check("R7", "slot0 first", mem_addr, 32'h200);
    @(negedge clk); #1;
    check("R7", "slot1 next cycle", mem_addr, 32'h300);
    check("R3", "write dir", 32'(mem_we), 1);
    @(negedge clk); #1;
    check("R3", "write addr", last_waddr, 32'h300);
    check("R3", "write data", last_wdata, 32'hDEAD_BEEF);
    check("R3", "one write", 32'(nwrites - w0), 1);
    check("R6", "both slots done", 32'(set_done[7:6]), 32'h3);
    check("R7", "back to slot0 idle", 32'(mem_req), 0);
    dreq[3] = 1'b0;
  endtask

  task automatic t_zero_len;
    logic [31:0] v;
    int w0;
    w0 = nwrites;
    load_slot(6, 0, 32'h0000_0600, 32'd3, 32'h1);
    dreq[6] = 1'b1;
    reg_write(ctl_a(6), 32'h1);
    #1;
    check("R8", "no mem access", 32'(mem_req), 0);
    check("R8", "not done yet", 32'(set_done[12]), 0);
    @(negedge clk); #1;
    check("R8", "done next cycle", 32'(set_done[12]), 1);
    reg_read(ctl_a(6), v); check("R8", "live slot flips", v, 32'h101);
    check("R8", "no memory write", 32'(nwrites - w0), 0);
    dreq[6] = 1'b0;
  endtask

  task automatic t_priority;
    load_slot(2, 0, 32'h0000_0400, 32'd4, 32'h1);
    load_slot(5, 0, 32'h0000_0500, 32'd4, 32'h1);
    reg_write(ctl_a(2), 32'h1);
    reg_write(ctl_a(5), 32'h1);
    dreq[2] = 1'b1; dreq[5] = 1'b1; #1;
    check("R9", "lower channel first", mem_addr, 32'h400);
    check("R9", "dack ch2", 32'(dack), 32'h04);
    @(negedge clk); #1;
    check("R9", "then ch5", mem_addr, 32'h500);
    check("R9", "dack ch5", 32'(dack), 32'h20);
    @(negedge clk); dreq = '0; #1;
    check("R9", "both done", 32'({set_done[10], set_done[4]}), 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_disabled_and_stall();
    t_single_then_idle();
    t_done_clear();
    t_pingpong();
    t_zero_len();
    t_priority();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule